// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupt-raising devices and a CPU. Eight level-sensitive request lines, each with a fixed rank (the line with the higher index ranks higher), and one non-maskable line are synchronized and priority-encoded. The controller keeps a register holding the level now being serviced. It raises a request toward the CPU only when the best pending line strictly outranks that level.

Once the CPU acknowledges, the controller points a one-hot acknowledge at the winning source. The source answers with a ready strobe, and the controller then emits a vector equal to a programmable base plus the winner's index. If the source stays silent for 16 cycles, a bus-error pulse is produced in place of the vector. Each accepted interrupt saves the old service level on an internal stack. An end-of-interrupt strobe restores it, so interrupts nest.

Top module: `prio_intc`

## Requirements
- R1: Each request input passes through two flops before selection. A new request that outranks the current level raises `cpu_req_o` at the third rising clock edge after the input changes.
- R2: Source index k ranges 0..7 for `irq_i[k]`, and the non-maskable input is index 8. The highest pending index wins. Service level is index+1, and level 0 means idle.
- R3: A pending source is requested only if its level is strictly greater than `cur_prio_o`. A source still asserted at the level now in service, or a lower one, produces no request.
- R4: The non-maskable input is requested whatever maskable level is in service.
- R5: `cpu_req_o` stays high until `cpu_ack_i` is sampled. It then falls, and `src_ack_o` holds a one-hot code with bit k set for winner k while the controller waits for the source.
- R6: When `src_rdy_i[k]` of the winner is sampled, `vec_valid_o` pulses for one cycle with `vec_o` = `vec_base_i` + k, and `cur_prio_o` becomes k+1 in the same cycle.
- R7: If the winner gives no ready within 16 cycles after the acknowledge edge, `bus_err_o` pulses for one cycle on the 16th edge. No vector is produced and `cur_prio_o` is unchanged.
- R8: Ready strobes from sources other than the current winner have no effect.
- R9: Accepting a vector pushes the previous level. A pulse on `eoi_i` restores the most recently saved level. `eoi_i` with nothing saved leaves the level at 0.
- R10: After reset, all outputs are low and `cur_prio_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Maskable level requests, index 7 highest |
| nmi_i | input | 1 | Non-maskable level request |
| vec_base_i | input | 8 | Base added to the winner index |
| cpu_req_o | output | 1 | Interrupt request to the CPU |
| cpu_ack_i | input | 1 | CPU acknowledge |
| src_ack_o | output | 9 | One-hot acknowledge to the winning source |
| src_rdy_i | input | 9 | Per-source vector-ready strobe |
| vec_valid_o | output | 1 | Vector delivered this cycle |
| vec_o | output | 8 | Handler vector |
| bus_err_o | output | 1 | Vector timeout pulse |
| eoi_i | input | 1 | End-of-interrupt, restores previous level |
| cur_prio_o | output | 4 | Level now in service |

## Verification
The bench drives mixed request patterns, including all lines at once and the non-maskable line alone. A wrong encoder would return the wrong vector in these cases. A source left asserted after service must not re-request, which catches a greater-or-equal comparison in place of strictly greater. The nesting sequence runs three levels deep with a masked low request waiting underneath, and checks that each end-of-interrupt restores the right level and finally releases the waiting request. A broken stack would unmask too early or never. The timeout case checks the exact cycle of the bus error and sends a ready strobe from a non-winning source. An off-by-one counter or a controller that listens to any ready would fail here.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} intc_st_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N_IN = 9,
  localparam int IW = $clog2(N_IN)
) (
  input  logic [N_IN-1:0] req_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o
);
  // later (higher) index overrides
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
  parameter int DEPTH = 9,
  parameter int W     = 4,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o
);
  logic [W-1:0]   mem_q [2**SPW];
  logic [SPW-1:0] sp_q;

  assign empty_o = (sp_q == '0);
  assign top_o   = empty_o ? '0 : mem_q[sp_q - SPW'(1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else if (push_i) sp_q <= sp_q + SPW'(1);
    else if (pop_i && !empty_o) sp_q <= sp_q - SPW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[sp_q] <= din_i;
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_SRC   = 8,
  parameter int VEC_W   = 8,
  parameter int TIMEOUT = 16,
  localparam int N_ALL  = N_SRC + 1,
  localparam int IW     = $clog2(N_ALL),
  localparam int PW     = $clog2(N_SRC + 2),
  localparam int CW     = $clog2(TIMEOUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             nmi_i,
  input  logic [VEC_W-1:0] vec_base_i,
  output logic             cpu_req_o,
  input  logic             cpu_ack_i,
  output logic [N_ALL-1:0] src_ack_o,
  input  logic [N_ALL-1:0] src_rdy_i,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             bus_err_o,
  input  logic             eoi_i,
  output logic [PW-1:0]    cur_prio_o
);
  import intc_pkg::*;

  intc_st_e      st_q;
  logic [N_ALL-1:0] req_s;
  logic          any;
  logic [IW-1:0] idx, win_q;
  logic [PW-1:0] pend_prio, cur_q, top;
  logic [CW-1:0] cnt_q;
  logic          take, push, empty;

  intc_sync #(.W(N_ALL)) u_sync (
    .clk_i, .rst_ni, .d_i({nmi_i, irq_i}), .q_o(req_s)
  );

  intc_prio_enc #(.N_IN(N_ALL)) u_enc (
    .req_i(req_s), .any_o(any), .idx_o(idx)
  );

  intc_prio_stack #(.DEPTH(N_ALL), .W(PW)) u_stk (
    .clk_i, .rst_ni, .push_i(push), .pop_i(eoi_i),
    .din_i(cur_q), .top_o(top), .empty_o(empty)
  );

  assign pend_prio = any ? PW'(idx) + PW'(1) : '0;
  assign take      = any && (pend_prio > cur_q);
  assign push      = (st_q == ST_WAIT) && src_rdy_i[win_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      win_q       <= '0;
      cnt_q       <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
      bus_err_o   <= 1'b0;
    end else begin
      vec_valid_o <= 1'b0;
      bus_err_o   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (take) st_q <= ST_REQ;
        ST_REQ: begin
          if (!take) st_q <= ST_IDLE;
          else if (cpu_ack_i) begin
            win_q <= idx;
            cnt_q <= '0;
            st_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (push) begin
            vec_valid_o <= 1'b1;
            vec_o       <= vec_base_i + VEC_W'(win_q);
            st_q        <= ST_IDLE;
          end else if (cnt_q == CW'(TIMEOUT - 1)) begin
            bus_err_o <= 1'b1;
            st_q      <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // push wins over a coincident end-of-interrupt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else if (push) cur_q <= PW'(win_q) + PW'(1);
    else if (eoi_i && !empty) cur_q <= top;
  end

  assign cpu_req_o  = (st_q == ST_REQ);
  assign src_ack_o  = (st_q == ST_WAIT) ? (N_ALL'(1) << win_q) : '0;
  assign cur_prio_o = cur_q;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_ALL   = 9,
  parameter int PW      = 4,
  parameter int TIMEOUT = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_req_o,
  input logic             cpu_ack_i,
  input logic [N_ALL-1:0] src_ack_o,
  input logic             vec_valid_o,
  input logic             bus_err_o,
  input logic             eoi_i,
  input logic [PW-1:0]    cur_prio_o
);
  logic [7:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wcnt_q <= '0;
    else if (src_ack_o != '0) wcnt_q <= wcnt_q + 8'd1;
    else wcnt_q <= '0;
  end

  AST_SRC_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_ack_o)); // R5
  AST_REQ_DROPS_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_o && cpu_ack_i) |=> (!cpu_req_o && src_ack_o != '0)); // R5
  AST_VEC_XOR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_valid_o && bus_err_o)); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= 8'(TIMEOUT)); // R7
  AST_LEVEL_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (cur_prio_o > $past(cur_prio_o))); // R6
  AST_LEVEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_valid_o && !$past(eoi_i)) |-> $stable(cur_prio_o)); // R9
endmodule

bind prio_intc prio_intc_chk #(.N_ALL(N_ALL), .PW(PW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_o(cpu_req_o), .cpu_ack_i(cpu_ack_i),
  .src_ack_o(src_ack_o), .vec_valid_o(vec_valid_o), .bus_err_o(bus_err_o),
  .eoi_i(eoi_i), .cur_prio_o(cur_prio_o)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int CLK_P = 10;
  localparam logic [7:0] BASE = 8'h40;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       nmi = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [8:0] rdy = '0;
  logic       cpu_req, vec_valid, bus_err;
  logic [8:0] src_ack;
  logic [7:0] vec;
  logic [3:0] cur;
  int total = 0, bad = 0;

  prio_intc uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi), .vec_base_i(BASE),
    .cpu_req_o(cpu_req), .cpu_ack_i(ack), .src_ack_o(src_ack), .src_rdy_i(rdy),
    .vec_valid_o(vec_valid), .vec_o(vec), .bus_err_o(bus_err), .eoi_i(eoi),
    .cur_prio_o(cur)
  );

  always #(CLK_P/2) clk = ~clk;

  // {pattern[8:0] (bit 8 = non-maskable), expected winner index}
  localparam logic [12:0] TBL [7] = '{
    {9'h001, 4'd0}, {9'h003, 4'd1}, {9'h0A4, 4'd7}, {9'h050, 4'd6},
    {9'h100, 4'd8}, {9'h1FF, 4'd8}, {9'h018, 4'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] p);
    irq = p[7:0];
    nmi = p[8];
  endtask

  task automatic serve(input int k);
    int n = 0;
    while (!cpu_req && n < 12) begin @(negedge clk); n++; end
    chk("R5 request seen", int'(cpu_req), 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R5 request dropped", int'(cpu_req), 0);
    chk("R5 source ack", int'(src_ack), 1 << k);
    rdy[k] = 1'b1;
    @(negedge clk);
    rdy = '0;
    chk("R6 vector valid", int'(vec_valid), 1);
    chk("R2 R6 vector", int'(vec), int'(BASE) + k);
    chk("R6 level", int'(cur), k + 1);
    @(negedge clk);
    chk("R6 single pulse", int'(vec_valid), 0);
  endtask

  task automatic pulse_eoi(input int exp_cur);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    chk("R9 restored level", int'(cur), exp_cur);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 req", int'(cpu_req), 0);
    chk("R10 src_ack", int'(src_ack), 0);
    chk("R10 vec_valid", int'(vec_valid), 0);
    chk("R10 bus_err", int'(bus_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 level", int'(cur), 0);
    pulse_eoi(0); // R9 empty stack

    // table walk: R2 R3
    for (int t = 0; t < 7; t++) begin
      drive(TBL[t][12:4]);
      serve(int'(TBL[t][3:0]));
      repeat (4) @(negedge clk);
      chk("R3 no re-request at own level", int'(cpu_req), 0);
      drive('0);
      repeat (3) @(negedge clk);
      pulse_eoi(0);
      @(negedge clk);
      chk("R9 idle after eoi", int'(cpu_req), 0);
    end

    // R1 latency
    irq = 8'h20;
    @(negedge clk);
    @(negedge clk);
    chk("R1 not before third edge", int'(cpu_req), 0);
    @(negedge clk);
    chk("R1 at third edge", int'(cpu_req), 1);
    serve(5);
    irq = '0;
    repeat (3) @(negedge clk);
    pulse_eoi(0);

    // nesting: R3 R4 R9
    irq = 8'h08;
    serve(3);
    irq = 8'h88;
    serve(7);
    irq = 8'h8C;
    repeat (6) @(negedge clk);
    chk("R3 lower masked", int'(cpu_req), 0);
    nmi = 1'b1;
    serve(8); // R4
    nmi = 1'b0;
    irq = 8'h04;
    repeat (3) @(negedge clk);
    pulse_eoi(8);
    pulse_eoi(4);
    chk("R3 still masked", int'(cpu_req), 0);
    pulse_eoi(0);
    chk("R3 no request same cycle", int'(cpu_req), 0);
    @(negedge clk);
    chk("R9 masked request released", int'(cpu_req), 1);
    serve(2);
    irq = '0;
    repeat (3) @(negedge clk);
    pulse_eoi(0);

    // timeout: R7 R8
    irq = 8'h08;
    begin
      int n = 0;
      while (!cpu_req && n < 12) begin @(negedge clk); n++; end
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    irq = '0;
    rdy[5] = 1'b1;
    repeat (14) @(negedge clk);
    chk("R8 foreign ready ignored", int'(vec_valid), 0);
    chk("R7 no early error", int'(bus_err), 0);
    rdy = '0;
    @(negedge clk);
    chk("R7 no error at 15", int'(bus_err), 0);
    @(negedge clk);
    chk("R7 error at 16", int'(bus_err), 1);
    chk("R7 no vector", int'(vec_valid), 0);
    chk("R7 level kept", int'(cur), 0);
    @(negedge clk);
    chk("R7 single pulse", int'(bus_err), 0);
    chk("R7 no retry", int'(cpu_req), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule